// File: doc/BRIEF.md
# Geometric Algebra Operation Sequencer

This block is the control sequencer of a geometric algebra coprocessor core. It stays in an idle state until a start request arrives. It then walks the arithmetic datapath through one operation. First it clears the working registers. Next it strobes operand capture. It then keeps the processing units enabled for a programmed number of cycles, holds the result write phase, and runs a memory dump phase. After that it returns to idle.

The lengths of the process, write and dump phases come from a 16-bit control word. The sequencer captures that word when it accepts start and holds it until the sequence finishes. The captured copy is also driven out, so the datapath can use it to pick its input and output paths. Start is the only external event. Every later step is taken automatically when the current phase's cycle budget runs out.

Top module: `ga_seq_ctrl`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the cycle after it, every strobe, `busy_o` and `done_o` are low.
- R2: With `start` low in idle, no strobe rises and `busy_o` stays low; a high `start` in idle makes `clr_o` high in the next cycle.
- R3: `cfg_o` takes the value of `ctrl_word` on the edge that accepts `start` and does not change until the next accepted start; `start` and `ctrl_word` activity while `busy_o` is high is ignored.
- R4: `clr_o` is high for exactly one cycle, the first cycle of every sequence.
- R5: `load_o` is high for exactly one cycle, directly after the clear cycle.
- R6: `proc_o` is high for N consecutive cycles right after the load cycle, where N is `cfg_o[7:0]`, and a value of 0 gives 1 cycle.
- R7: `wr_o` follows for `cfg_o[11:8]` cycles, then `dump_o` follows for `cfg_o[15:12]` cycles; a field value of 0 gives 1 cycle.
- R8: At most one of `clr_o`, `load_o`, `proc_o`, `wr_o`, `dump_o` is high at a time, and `busy_o` is high exactly when one of them is.
- R9: `done_o` is high for one cycle only, the final dump cycle, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin one operation |
| ctrl_word | input | 16 | Control word: process, write and dump lengths and path select |
| clr_o | output | 1 | Clear working registers |
| load_o | output | 1 | Capture operands |
| proc_o | output | 1 | Enable processing units |
| wr_o | output | 1 | Write out result |
| dump_o | output | 1 | Memory dump phase |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Final cycle of the sequence |
| cfg_o | output | 16 | Captured control word |

## Verification
The control words tried are these:
- All fields zero, which checks that zero is clamped to one cycle in every phase.
- All fields at their maximum, which checks that the counter holds the full 8-bit process count.
- Mixed words with small, odd and single-cycle fields, which check that each field goes to its own phase and not to a neighbour.

During each run the bench raises start with an inverted control word. A captured intrusion would change both the phase lengths and the captured word, so it shows up. A reset in the middle of a run, and idle stretches with a changing control word, separate correct launch behaviour from strobes that leak out without a start.

// File: rtl/ga_seq_ctrl.sv
module ga_seq_ctrl #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int WW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] ctrl_word,
  output logic          clr_o,
  output logic          load_o,
  output logic          proc_o,
  output logic          wr_o,
  output logic          dump_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cfg_o
);
  localparam int W_LO  = PW;
  localparam int D_LO  = PW + WW;
  localparam int CNT_W = (PW > WW) ? ((PW > DW) ? PW : DW) : ((WW > DW) ? WW : DW);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_LOAD, S_PROC, S_WR, S_DUMP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    cfg_q;
  logic [CNT_W-1:0] p_len, w_len, d_len;
  logic             last;

  assign p_len = (cfg_q[PW-1:0] == '0) ? CNT_W'(1) : CNT_W'(cfg_q[PW-1:0]);
  assign w_len = (cfg_q[W_LO+:WW] == '0) ? CNT_W'(1) : CNT_W'(cfg_q[W_LO+:WW]);
  assign d_len = (cfg_q[D_LO+:DW] == '0) ? CNT_W'(1) : CNT_W'(cfg_q[D_LO+:DW]);
  assign last  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      cfg_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_CLR;
          cfg_q <= ctrl_word;
        end
        S_CLR:  st <= S_LOAD;
        S_LOAD: begin
          st  <= S_PROC;
          cnt <= p_len - CNT_W'(1);
        end
        S_PROC: if (last) begin
          st  <= S_WR;
          cnt <= w_len - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        S_WR: if (last) begin
          st  <= S_DUMP;
          cnt <= d_len - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        S_DUMP: if (last) st <= S_IDLE;
                else cnt <= cnt - CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assign clr_o  = (st == S_CLR);
  assign load_o = (st == S_LOAD);
  assign proc_o = (st == S_PROC);
  assign wr_o   = (st == S_WR);
  assign dump_o = (st == S_DUMP);
  assign busy_o = (st != S_IDLE);
  assign done_o = (st == S_DUMP) && last;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/ga_seq_ctrl_chk.sv
module ga_seq_ctrl_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          clr_o,
  input logic          load_o,
  input logic          proc_o,
  input logic          wr_o,
  input logic          dump_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] cfg_o
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy_o && !done_o));
  a_r2_launch: assert property (@(posedge clk) disable iff (rst) (!busy_o && start) |=> clr_o);
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(cfg_o));
  a_r4_clr_once: assert property (@(posedge clk) disable iff (rst) clr_o |=> (load_o && !clr_o));
  a_r5_load_once: assert property (@(posedge clk) disable iff (rst) load_o |=> proc_o);
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_o, load_o, proc_o, wr_o, dump_o}));
  a_r8_busy_match: assert property (@(posedge clk) disable iff (rst)
    busy_o == (clr_o | load_o | proc_o | wr_o | dump_o));
  a_r9_done_in_dump: assert property (@(posedge clk) disable iff (rst) done_o |-> dump_o);
  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (rst) done_o |=> !busy_o);
endmodule

bind ga_seq_ctrl ga_seq_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .clr_o(clr_o), .load_o(load_o),
  .proc_o(proc_o), .wr_o(wr_o), .dump_o(dump_o), .busy_o(busy_o),
  .done_o(done_o), .cfg_o(cfg_o)
);

// File: tb/ga_seq_ctrl_tb_top.sv
module ga_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] ctrl_word = 16'h0;
  logic clr_o, load_o, proc_o, wr_o, dump_o, busy_o, done_o;
  logic [15:0] cfg_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ga_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
    .clr_o(clr_o), .load_o(load_o), .proc_o(proc_o), .wr_o(wr_o),
    .dump_o(dump_o), .busy_o(busy_o), .done_o(done_o), .cfg_o(cfg_o)
  );

  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{16'h0000, 16'hFFFF, 16'h3205, 16'h0100,
                                       16'h8A01, 16'h2311, 16'h10C8};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_seq(input logic [15:0] w);
    int n_clr = 0, n_load = 0, n_proc = 0, n_wr = 0, n_dump = 0, n_done = 0;
    int phase = 0, order_bad = 0, multi = 0, cfg_bad = 0, done_bad = 0, cyc = 0;
    int first_clr = 0;
    logic prev_done = 1'b0;
    @(negedge clk);
    start = 1'b1;
    ctrl_word = w;
    @(negedge clk);
    start = 1'b0;
    ctrl_word = ~w;
    first_clr = clr_o;
    while (busy_o && cyc < 2000) begin
      int ph;
      if (($countones({clr_o, load_o, proc_o, wr_o, dump_o})) != 1) multi++;
      ph = clr_o ? 1 : load_o ? 2 : proc_o ? 3 : wr_o ? 4 : 5;
      if (ph < phase) order_bad++;
      phase = ph;
      n_clr += clr_o; n_load += load_o; n_proc += proc_o;
      n_wr += wr_o; n_dump += dump_o; n_done += done_o;
      if (done_o && !dump_o) done_bad++;
      if (cfg_o != w) cfg_bad++;
      prev_done = done_o;
      cyc++;
      if (cyc == 3) begin start = 1'b1; ctrl_word = ~w; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2 clear right after start", first_clr, 1);
    chk("R3 captured word held", cfg_bad, 0);
    chk("R4 clear cycles", n_clr, 1);
    chk("R5 load cycles", n_load, 1);
    chk("R6 process cycles", n_proc, clamp(int'(w[7:0])));
    chk("R7 write cycles", n_wr, clamp(int'(w[11:8])));
    chk("R7 dump cycles", n_dump, clamp(int'(w[15:12])));
    chk("R8 phase order", order_bad, 0);
    chk("R8 single strobe", multi, 0);
    chk("R9 done count", n_done, 1);
    chk("R9 done in last cycle", int'(prev_done) + done_bad * 10, 1);
    chk("R3 intrusion ignored total", cyc,
        2 + clamp(int'(w[7:0])) + clamp(int'(w[11:8])) + clamp(int'(w[15:12])));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset strobes", {27'd0, clr_o, load_o, proc_o, wr_o, dump_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset done", done_o, 0);

    for (int i = 0; i < 10; i++) begin
      ctrl_word = 16'h1111 * i[15:0];
      @(negedge clk);
      chk("R2 idle without start", int'(busy_o) + int'(done_o), 0);
      chk("R3 idle word not captured", cfg_o, 0);
    end

    for (int v = 0; v < NV; v++) run_seq(VEC[v]);

    @(negedge clk);
    start = 1'b1; ctrl_word = 16'h0F40;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset busy", busy_o, 0);
    chk("R1 mid-run reset strobes", {27'd0, clr_o, load_o, proc_o, wr_o, dump_o}, 0);
    rst = 1'b0;
    run_seq(16'h5301);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule